// File: doc/BRIEF.md
# Space-Vector PWM Gate Generator

This block turns a space-vector command into gate drive for a two-level inverter with three legs. For each switching period it takes a sector code and the dwell times of the two active vectors. From these it derives the zero-vector time and one on-time per leg. The zero time is split evenly between the all-low and the all-high leg states, and a per-sector table places the remaining dwell times on the legs.

An up-counting sawtooth carrier runs from zero to one below the period length and then wraps. Each leg's on-time is compared with this carrier to form the upper-switch command. A dead-time stage per leg drives a complementary pair of upper and lower gates from that command, with a programmable gap. The period, the sector and the dwell times are taken only at the carrier wrap, so a command changes the outputs only at period boundaries. The vector computation that feeds this block is a separate stage.

Top module: `svpwm_gate_gen`

## Requirements
- R1: While `rst` is high, and in the first clock cycle after it is released, every upper and lower gate is low.
- R2: The carrier counts 0, 1, …, Ts−1 and then returns to 0, so one switching period lasts Ts clock cycles. Ts is taken from `period_i` at each wrap, and at the first edge after reset.
- R3: Sector, Tx, Ty and Ts are sampled only in the clock cycle where the carrier wraps. Changes at any other time have no effect on the gates until the next period.
- R4: The zero-vector time is T0 = Ts − Tx − Ty, and the half share used by every leg is floor(T0/2). With Tx = Ty = 0 and an odd Ts, every leg has an on-time of (Ts−1)/2.
- R5: For sector codes 1 to 6, the leg on-times (A,B,C) are as follows, with h = floor(T0/2):
  - 1: (Tx+Ty+h, Ty+h, h)
  - 2: (Tx+h, Tx+Ty+h, h)
  - 3: (h, Tx+Ty+h, Ty+h)
  - 4: (h, Tx+h, Tx+Ty+h)
  - 5: (Ty+h, h, Tx+Ty+h)
  - 6: (Tx+Ty+h, h, Tx+h)
- R6: A leg's upper command is high while the carrier value is below its on-time and low otherwise. With zero dead time, the upper gate follows this command one clock later and the lower gate is its complement. Leg A is bit 0, B is bit 1 and C is bit 2 of the gate buses.
- R7: If Tx > Ts, Tx is taken as Ts and Ty as 0. Otherwise, if Tx+Ty > Ts, Ty is taken as Ts−Tx. T0 is therefore never negative, and no on-time exceeds Ts.
- R8: A sector code of 0 or 7 turns off both gates of all three legs for the whole period it is sampled for.
- R9: After every edge of a leg's upper command, both gates of that leg stay low for N clock cycles, where N is the value of `dead_i` at that edge. The new gate then turns on. An edge that arrives during the gap restarts it.
- R10: The upper and lower gates of one leg are never high in the same cycle, and a gate that turns off is not followed in the same cycle by its partner turning on unless N is 0.

Port list, in declaration order:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| period_i | input | TW | Switching period Ts in clock cycles |
| sector_i | input | 3 | Sector code, valid values 1 to 6 |
| tx_i | input | TW | First active-vector dwell time Tx |
| ty_i | input | TW | Second active-vector dwell time Ty |
| dead_i | input | DW | Dead time N in clock cycles |
| gate_hi_o | output | 3 | Upper gates, bit 0 = leg A |
| gate_lo_o | output | 3 | Lower gates, bit 0 = leg A |

## Verification
The bench builds the block with TW = 8 and DW = 4. These values put short periods of a few cycles and dwell sums that exceed Ts within reach, so the clamp and the odd-T0 rounding both occur often. The 4-bit dead time can be longer than many of the pulses, so the bench reaches pulses that are swallowed by the gap and edges that arrive while a gap is still running. Every sector code, including the two invalid ones, and commands changed in the middle of a period are also applied.

// File: rtl/svpwm_pkg.sv
package svpwm_pkg;

    typedef logic [2:0] sector_t;

    localparam sector_t SEC_FIRST = 3'd1;
    localparam sector_t SEC_LAST  = 3'd6;
    localparam int unsigned NUM_LEGS = 3;

    function automatic logic sector_ok(input sector_t s);
        return (s >= SEC_FIRST) && (s <= SEC_LAST);
    endfunction

endpackage

// File: rtl/svpwm_carrier.sv
module svpwm_carrier #(
    parameter int unsigned TW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [TW-1:0] period_i,
    output logic [TW-1:0] cnt_o,
    output logic [TW-1:0] per_o,
    output logic          wrap_o
);

    typedef struct packed {
        logic [TW-1:0] cnt;
        logic [TW-1:0] per;
    } car_t;

    car_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        wrap_o = ({1'b0, st_q.cnt} + 1'b1) >= {1'b0, st_q.per};
        if (wrap_o) begin
            st_d.cnt = '0;
            st_d.per = period_i;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;
    assign per_o = st_q.per;

    // R2
    carrier_range_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.cnt < st_q.per) || ((st_q.per == '0) && (st_q.cnt == '0)));

endmodule

// File: rtl/svpwm_ontime.sv
module svpwm_ontime
    import svpwm_pkg::*;
#(
    parameter int unsigned TW = 12
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wrap_i,
    input  logic [TW-1:0]               ts_i,
    input  sector_t                     sector_i,
    input  logic [TW-1:0]               tx_i,
    input  logic [TW-1:0]               ty_i,
    input  logic [TW-1:0]               per_i,
    output logic                        valid_o,
    output logic [NUM_LEGS-1:0][TW-1:0] on_o
);

    typedef struct packed {
        logic                        valid;
        logic [NUM_LEGS-1:0][TW-1:0] on;
    } ot_t;

    ot_t st_d, st_q;

    logic [TW:0]   sum_xy;
    logic [TW-1:0] txc, tyc, t0, half;
    logic [TW-1:0] t_long, t_midx, t_midy;

    always_comb begin
        sum_xy = {1'b0, tx_i} + {1'b0, ty_i};
        if (tx_i > ts_i) begin
            txc = ts_i;
            tyc = '0;
        end else if (sum_xy > {1'b0, ts_i}) begin
            txc = tx_i;
            tyc = ts_i - tx_i;
        end else begin
            txc = tx_i;
            tyc = ty_i;
        end
        t0     = ts_i - txc - tyc;
        half   = t0 >> 1;
        t_long = txc + tyc + half;
        t_midx = txc + half;
        t_midy = tyc + half;
    end

    always_comb begin
        st_d = st_q;
        if (wrap_i) begin
            st_d.valid = sector_ok(sector_i);
            case (sector_i)
                3'd1:    st_d.on = {half,   t_midy, t_long};
                3'd2:    st_d.on = {half,   t_long, t_midx};
                3'd3:    st_d.on = {t_midy, t_long, half};
                3'd4:    st_d.on = {t_long, t_midx, half};
                3'd5:    st_d.on = {t_long, half,   t_midy};
                3'd6:    st_d.on = {t_midx, half,   t_long};
                default: st_d.on = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o = st_q.valid;
    assign on_o    = st_q.on;

    logic [TW-1:0] on_max, on_min;
    always_comb begin
        on_max = st_q.on[0];
        on_min = st_q.on[0];
        for (int k = 1; k < NUM_LEGS; k++) begin
            if (st_q.on[k] > on_max) on_max = st_q.on[k];
            if (st_q.on[k] < on_min) on_min = st_q.on[k];
        end
    end

    // R7
    ontime_bound_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.valid |-> (on_max <= per_i));

    // R4
    zero_split_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.valid |-> (({1'b0, per_i} - ({1'b0, on_max} - {1'b0, on_min})
                         - {on_min, 1'b0}) <= 1));

    // R8
    invalid_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !st_q.valid |-> (on_max == '0));

endmodule

// File: rtl/svpwm_deadband.sv
module svpwm_deadband #(
    parameter int unsigned DW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          raw_i,
    input  logic          off_i,
    input  logic [DW-1:0] dead_i,
    output logic          hi_o,
    output logic          lo_o
);

    typedef struct packed {
        logic          cur;
        logic [DW-1:0] dc;
        logic          off;
    } db_t;

    db_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.off = off_i;
        if (raw_i != st_q.cur) begin
            st_d.cur = raw_i;
            st_d.dc  = dead_i;
        end else if (st_q.dc != '0) begin
            st_d.dc = st_q.dc - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= '0;
            st_q.off <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    logic settled;
    assign settled = (st_q.dc == '0) && !st_q.off;
    assign hi_o    = settled &&  st_q.cur;
    assign lo_o    = settled && !st_q.cur;

    // R10
    no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        !(hi_o && lo_o));

    // R9
    gap_after_hi_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(hi_o) |-> (!lo_o || ($past(dead_i) == '0)));

endmodule

// File: rtl/svpwm_gate_gen.sv
module svpwm_gate_gen
    import svpwm_pkg::*;
#(
    parameter int unsigned TW = 12,
    parameter int unsigned DW = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [TW-1:0]       period_i,
    input  logic [2:0]          sector_i,
    input  logic [TW-1:0]       tx_i,
    input  logic [TW-1:0]       ty_i,
    input  logic [DW-1:0]       dead_i,
    output logic [NUM_LEGS-1:0] gate_hi_o,
    output logic [NUM_LEGS-1:0] gate_lo_o
);

    logic [TW-1:0]               cnt, per;
    logic                        wrap;
    logic                        valid;
    logic [NUM_LEGS-1:0][TW-1:0] on_t;
    logic [NUM_LEGS-1:0]         raw;

    svpwm_carrier #(.TW(TW)) u_carrier (
        .clk      (clk),
        .rst      (rst),
        .period_i (period_i),
        .cnt_o    (cnt),
        .per_o    (per),
        .wrap_o   (wrap)
    );

    svpwm_ontime #(.TW(TW)) u_ontime (
        .clk      (clk),
        .rst      (rst),
        .wrap_i   (wrap),
        .ts_i     (period_i),
        .sector_i (sector_i),
        .tx_i     (tx_i),
        .ty_i     (ty_i),
        .per_i    (per),
        .valid_o  (valid),
        .on_o     (on_t)
    );

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        assign raw[g] = valid && (cnt < on_t[g]);

        svpwm_deadband #(.DW(DW)) u_db (
            .clk    (clk),
            .rst    (rst),
            .raw_i  (raw[g]),
            .off_i  (!valid),
            .dead_i (dead_i),
            .hi_o   (gate_hi_o[g]),
            .lo_o   (gate_lo_o[g])
        );
    end

    // R1
    first_cycle_off_chk: assert property (@(posedge clk)
        $fell(rst) |-> ((gate_hi_o == '0) && (gate_lo_o == '0)));

endmodule

// File: tb/svpwm_gate_gen_test.sv
module svpwm_gate_gen_test;

    localparam int TW = 8;
    localparam int DW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [TW-1:0] period_i = '0;
    logic [2:0]    sector_i = '0;
    logic [TW-1:0] tx_i = '0;
    logic [TW-1:0] ty_i = '0;
    logic [DW-1:0] dead_i = '0;
    logic [2:0]    gate_hi_o, gate_lo_o;

    svpwm_gate_gen #(.TW(TW), .DW(DW)) uut (
        .clk       (clk),
        .rst       (rst),
        .period_i  (period_i),
        .sector_i  (sector_i),
        .tx_i      (tx_i),
        .ty_i      (ty_i),
        .dead_i    (dead_i),
        .gate_hi_o (gate_hi_o),
        .gate_lo_o (gate_lo_o)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    string tag = "R1";

    int m_cnt, m_per, m_on[3], m_dc[3];
    bit m_valid, m_off, m_cur[3];

    // Expected on-time from the sector table (R4, R5, R7).
    function automatic int exp_on(int leg, int s, int tx, int ty, int ts);
        int h, longleg, shortleg;
        if (tx > ts) begin
            tx = ts; ty = 0;
        end else if (tx + ty > ts) begin
            ty = ts - tx;
        end
        h = (ts - tx - ty) / 2;
        case (s)
            1: begin longleg = 0; shortleg = 2; end
            2: begin longleg = 1; shortleg = 2; end
            3: begin longleg = 1; shortleg = 0; end
            4: begin longleg = 2; shortleg = 0; end
            5: begin longleg = 2; shortleg = 1; end
            6: begin longleg = 0; shortleg = 1; end
            default: return 0;
        endcase
        if (leg == longleg) return tx + ty + h;
        if (leg == shortleg) return h;
        return ((s % 2) == 1) ? ty + h : tx + h;
    endfunction

    task automatic model_reset();
        m_cnt = 0; m_per = 0; m_valid = 0; m_off = 1;
        for (int k = 0; k < 3; k++) begin
            m_on[k] = 0; m_cur[k] = 0; m_dc[k] = 0;
        end
    endtask

    task automatic model_step();
        bit raw[3];
        bit n_off;
        for (int k = 0; k < 3; k++) raw[k] = m_valid && (m_cnt < m_on[k]);
        for (int k = 0; k < 3; k++) begin
            if (raw[k] != m_cur[k]) begin
                m_cur[k] = raw[k];
                m_dc[k]  = int'(dead_i);
            end else if (m_dc[k] > 0) begin
                m_dc[k] = m_dc[k] - 1;
            end
        end
        n_off = !m_valid;
        if (m_cnt + 1 >= m_per) begin
            m_cnt   = 0;
            m_per   = int'(period_i);
            m_valid = (sector_i >= 1) && (sector_i <= 6);
            for (int k = 0; k < 3; k++)
                m_on[k] = exp_on(k, int'(sector_i), int'(tx_i), int'(ty_i), m_per);
        end else begin
            m_cnt = m_cnt + 1;
        end
        m_off = n_off;
    endtask

    task automatic check_outputs();
        logic [2:0] eh, el;
        for (int k = 0; k < 3; k++) begin
            eh[k] = !m_off && (m_dc[k] == 0) &&  m_cur[k];
            el[k] = !m_off && (m_dc[k] == 0) && !m_cur[k];
        end
        checks++;
        if (gate_hi_o !== eh || gate_lo_o !== el) begin
            fails++;
            $display("FAIL %s gates hi=%b lo=%b expected hi=%b lo=%b at t=%0t",
                     tag, gate_hi_o, gate_lo_o, eh, el, $time);
        end
        checks++;
        if ((gate_hi_o & gate_lo_o) !== 3'b000) begin
            fails++;
            $display("FAIL R10 overlap hi=%b lo=%b expected no common bit",
                     gate_hi_o, gate_lo_o);
        end
    endtask

    // Inputs are set after a falling edge; the model takes the next rising edge.
    task automatic cycle();
        if (rst) model_reset(); else model_step();
        @(negedge clk);
        check_outputs();
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    task automatic cmd(int per, int s, int tx, int ty, int dt);
        period_i = per[TW-1:0];
        sector_i = s[2:0];
        tx_i     = tx[TW-1:0];
        ty_i     = ty[TW-1:0];
        dead_i   = dt[DW-1:0];
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        int seed_v;
        seed_v = $urandom(32'h5e3d1);
        model_reset();
        @(negedge clk);
        tag = "R1";
        cmd(20, 1, 5, 3, 2);
        for (int i = 0; i < 5; i++) cycle();
        rst = 1'b0;
        cycle();

        tag = "R5";
        for (int s = 1; s <= 6; s++) begin
            cmd(20, s, 6, 3, 1);
            run(45);
        end

        tag = "R4";
        cmd(21, 2, 0, 0, 0);
        run(50);

        tag = "R2";
        cmd(13, 3, 4, 2, 1);
        run(40);
        cmd(40, 4, 10, 7, 2);
        run(90);
        cmd(2, 1, 1, 0, 0);
        run(12);

        tag = "R3";
        for (int i = 0; i < 20; i++) begin
            cmd(30, (i % 6) + 1, 3 + i % 5, 8 - i % 4, 1);
            run(7);
        end

        tag = "R7";
        cmd(20, 1, 18, 9, 0);
        run(45);
        cmd(20, 5, 25, 3, 1);
        run(45);
        cmd(20, 6, 20, 20, 0);
        run(45);

        tag = "R8";
        cmd(24, 0, 5, 5, 1);
        run(50);
        cmd(24, 7, 5, 5, 1);
        run(50);
        cmd(24, 3, 5, 5, 1);
        run(50);

        tag = "R9";
        cmd(40, 1, 10, 6, 0);
        run(90);
        cmd(40, 2, 3, 2, 15);
        run(90);
        cmd(40, 4, 12, 1, 7);
        run(90);

        tag = "R6";
        for (int i = 0; i < 15000; i++) begin
            if (($urandom % 16) == 0) begin
                int per;
                per = 2 + int'($urandom % 79);
                cmd(per, int'($urandom % 8), int'($urandom % (per + 4)),
                    int'($urandom % (per + 4)), int'($urandom % 16));
            end
            cycle();
        end

        tag = "R1";
        rst = 1'b1;
        run(3);
        rst = 1'b0;
        cycle();

        finish_run();
    end

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 150000 && !done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired cycles=%0d expected below 150000", wd);
            finish_run();
        end
    end

endmodule